// File: doc/BRIEF.md
# Real-Time Clock Register Block with Event Interrupts

This block keeps wall-clock time for a chip: a sub-second tick counter advanced by an external tick pulse, and a 32-bit seconds counter that steps each time the tick counter reaches a programmable calibration limit. Software reaches it through a simple single-cycle register port. A write lands on the next rising clock edge. Read data is driven combinationally from the addressed register during the same cycle. Only aligned word accesses are decoded.

Two interrupt groups report events. The timekeeping group has two event bits: one for every seconds step and one for an alarm match. The address-error group has one bit, which records any access that decodes to no register. Each group has a status register cleared by writing ones, a mask register that software cannot write directly, and a pair of strobe registers that clear or set mask bits. Each group drives a level interrupt output that is high while any unmasked status bit is set.

Top module: `rtcr_top`

## Requirements
- R1: Byte offsets: set-time write 0x00, set-time readback 0x04, calibration write 0x08, calibration readback 0x0C, current time 0x10, current tick 0x14, alarm 0x18, event status 0x20, event mask 0x24, event enable 0x28, event disable 0x2C, address-error status 0x30, address-error mask 0x34, address-error enable 0x38, address-error disable 0x3C, control 0x40, safety check 0x50. Offsets 0x04 and 0x10 both read the seconds count. Offset 0x0C reads the 21-bit calibration value, zero-extended. Offset 0x14 reads the 16-bit tick count, zero-extended. Offsets 0x00 and 0x08 read zero. Writes to 0x04, 0x0C, 0x10, 0x14, 0x24 and 0x34 change nothing and raise no address error.
- R2: Each cycle with `tick_pulse` high advances the tick count by one. When `tick_pulse` is high and the tick count equals the low 16 bits of the calibration value, the tick count returns to 0 and the seconds count increments by one. This is a seconds boundary.
- R3: A write to 0x00 does not change the seconds count right away. At the next seconds boundary the written value is loaded into the seconds count in place of the increment.
- R4: Event status bit 0 sets on every seconds boundary. Event status bit 1 sets on a seconds boundary when the new seconds value equals the alarm register.
- R5: Writing to a status register clears each bit written as one and leaves each bit written as zero. If an event and a clear reach the same bit in the same cycle, the event wins.
- R6: After reset every mask bit is one. A write to the enable offset clears each mask bit written as one. A write to the disable offset sets each mask bit written as one. The enable and disable offsets read zero.
- R7: `irq_rtc` is high exactly when some event status bit is one and its mask bit is zero.
- R8: An access to an unmapped or misaligned address (addr[1:0] not zero), whether read or write, sets address-error status bit 0. Such an access changes no other register and reads zero. The address-error group works like R5 and R6 with one bit and drives `irq_aerr`.
- R9: The control register resets to 0x01000000. Only bits 31, 27:24 and 0 (mask 0x8F000001) are writable. All other bits read zero.
- R10: The alarm and safety-check registers are plain 32-bit read/write registers that reset to zero.
- R11: After reset the seconds count, tick count and both status registers are zero, the calibration value is `CAL_RST`, and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_pulse | input | 1 | One-cycle sub-second tick from the oscillator domain |
| bus_req | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, same cycle |
| irq_rtc | output | 1 | Timekeeping event interrupt, level |
| irq_aerr | output | 1 | Address-error interrupt, level |

## Verification
The bench builds the block with `CAL_RST` set to 4. It then writes a calibration limit of 3 and later 0, so seconds boundaries arrive after four tick pulses and then after every pulse. This brings the set-time load, alarm matches several seconds ahead and an event colliding with a status clear within a few dozen cycles. `ADDR_W` stays at 8, so the unmapped gap at 0x1C, the region past 0x50 and misaligned offsets can all be reached.

// File: rtl/rtcr_pkg.sv
package rtcr_pkg;

  localparam int DATA_W = 32;

  localparam logic [DATA_W-1:0] CTRL_RST   = 32'h0100_0000;
  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h8F00_0001;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_SETW, SEL_SETR, SEL_CALW, SEL_CALR, SEL_TIME, SEL_TICK,
    SEL_ALARM, SEL_ESTS, SEL_EMSK, SEL_EEN, SEL_EDIS, SEL_ASTS, SEL_AMSK,
    SEL_AEN, SEL_ADIS, SEL_CTRL, SEL_SAFE
  } sel_e;

  // Offset decode; any offset not listed (including misaligned) maps to none.
  function automatic sel_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      8'h00:   return SEL_SETW;
      8'h04:   return SEL_SETR;
      8'h08:   return SEL_CALW;
      8'h0C:   return SEL_CALR;
      8'h10:   return SEL_TIME;
      8'h14:   return SEL_TICK;
      8'h18:   return SEL_ALARM;
      8'h20:   return SEL_ESTS;
      8'h24:   return SEL_EMSK;
      8'h28:   return SEL_EEN;
      8'h2C:   return SEL_EDIS;
      8'h30:   return SEL_ASTS;
      8'h34:   return SEL_AMSK;
      8'h38:   return SEL_AEN;
      8'h3C:   return SEL_ADIS;
      8'h40:   return SEL_CTRL;
      8'h50:   return SEL_SAFE;
      default: return SEL_NONE;
    endcase
  endfunction

  // Control write: reserved positions forced to zero.
  function automatic logic [DATA_W-1:0] ctrl_merge(input logic [DATA_W-1:0] wd);
    return wd & CTRL_WMASK;
  endfunction

endpackage

// File: rtl/rtcr_timebase.sv
module rtcr_timebase #(
  parameter int TICK_W = 16,
  parameter int SEC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_pulse,
  input  logic [TICK_W-1:0] tick_limit,
  input  logic              load_wr,
  input  logic [SEC_W-1:0]  load_val,
  output logic [TICK_W-1:0] tick_q,
  output logic [SEC_W-1:0]  sec_q,
  output logic              sec_step,
  output logic [SEC_W-1:0]  sec_next
);

  logic             pend_q;
  logic [SEC_W-1:0] pend_val_q;

  function automatic logic [TICK_W-1:0] adv_tick(input logic [TICK_W-1:0] t,
                                                 input logic wrap);
    return wrap ? '0 : t + 1'b1;
  endfunction

  assign sec_step = tick_pulse && (tick_q == tick_limit);
  assign sec_next = pend_q ? pend_val_q : sec_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q     <= '0;
      sec_q      <= '0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
    end else begin
      if (tick_pulse) tick_q <= adv_tick(tick_q, sec_step);
      if (sec_step)   sec_q  <= sec_next;
      if (load_wr) begin
        pend_q     <= 1'b1;
        pend_val_q <= load_val;
      end else if (sec_step) begin
        pend_q     <= 1'b0;
      end
    end
  end

  // R2: tick only moves on a pulse
  a_r2_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_pulse |=> $stable(tick_q));
  // R2: seconds only move at a boundary
  a_r2_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_step |=> $stable(sec_q));
  // R2: boundary without pending load increments
  a_r2_sec_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && !pend_q) |=> sec_q == $past(sec_q) + 1'b1);
  // R3: pending set-time value lands at the boundary
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && pend_q) |=> sec_q == $past(pend_val_q));

endmodule

// File: rtl/rtcr_irq_grp.sv
module rtcr_irq_grp #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         w1c_stb,
  input  logic         en_stb,
  input  logic         dis_stb,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] sts_q,
  output logic [W-1:0] msk_q,
  output logic         irq
);

  logic [W-1:0] clr_bits;
  assign clr_bits = w1c_stb ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      msk_q <= '1;
    end else begin
      sts_q <= (sts_q & ~clr_bits) | evt;
      if (en_stb)       msk_q <= msk_q & ~wbits;
      else if (dis_stb) msk_q <= msk_q | wbits;
    end
  end

  assign irq = |(sts_q & ~msk_q);

  // R5: an event always lands, even against a clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> (sts_q & $past(evt)) == $past(evt));
  // R5: written ones clear when no event collides
  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    w1c_stb |=> (sts_q & $past(wbits) & ~$past(evt)) == '0);
  // R6: enable strobe clears the addressed mask bits
  a_r6_enable: assert property (@(posedge clk) disable iff (!rst_n)
    en_stb |=> (msk_q & $past(wbits)) == '0);
  // R6: disable strobe sets the addressed mask bits
  a_r6_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_stb && !en_stb) |=> (msk_q & $past(wbits)) == $past(wbits));
  // R6: mask moves only through the strobes
  a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_stb && !dis_stb) |=> $stable(msk_q));

endmodule

// File: rtl/rtcr_top.sv
module rtcr_top #(
  parameter int ADDR_W  = 8,
  parameter int TICK_W  = 16,
  parameter int CAL_W   = 21,
  parameter int CAL_RST = 32'h7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_pulse,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_rtc,
  output logic              irq_aerr
);
  import rtcr_pkg::*;

  localparam int SEC_W = DATA_W;
  localparam int EVT_W = 2;
  localparam int AER_W = 1;

  logic              hi_ok;
  sel_e              sel;
  logic              wr_en;
  logic [CAL_W-1:0]  calib_q;
  logic [DATA_W-1:0] alarm_q, ctrl_q, safe_q;
  logic [TICK_W-1:0] tick_q;
  logic [SEC_W-1:0]  sec_q, sec_next;
  logic              sec_step, alarm_hit, aerr_evt;
  logic [EVT_W-1:0]  ev_sts, ev_msk;
  logic [AER_W-1:0]  ae_sts, ae_msk;

  // Address bits above the 8-bit window must be zero to decode.
  if (ADDR_W > 8) begin : g_hi
    assign hi_ok = ~|bus_addr[ADDR_W-1:8];
  end else begin : g_nohi
    assign hi_ok = 1'b1;
  end

  assign sel      = hi_ok ? decode_ofs(bus_addr[7:0]) : SEL_NONE;
  assign wr_en    = bus_req && bus_wr;
  assign aerr_evt = bus_req && (sel == SEL_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      calib_q <= CAL_W'(CAL_RST);
      alarm_q <= '0;
      ctrl_q  <= CTRL_RST;
      safe_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_CALW:  calib_q <= bus_wdata[CAL_W-1:0];
        SEL_ALARM: alarm_q <= bus_wdata;
        SEL_CTRL:  ctrl_q  <= ctrl_merge(bus_wdata);
        SEL_SAFE:  safe_q  <= bus_wdata;
        default:   ;
      endcase
    end
  end

  rtcr_timebase #(.TICK_W(TICK_W), .SEC_W(SEC_W)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_pulse (tick_pulse),
    .tick_limit (calib_q[TICK_W-1:0]),
    .load_wr    (wr_en && sel == SEL_SETW),
    .load_val   (bus_wdata),
    .tick_q     (tick_q),
    .sec_q      (sec_q),
    .sec_step   (sec_step),
    .sec_next   (sec_next)
  );

  assign alarm_hit = sec_step && (sec_next == alarm_q);

  rtcr_irq_grp #(.W(EVT_W)) u_ev (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     ({alarm_hit, sec_step}),
    .w1c_stb (wr_en && sel == SEL_ESTS),
    .en_stb  (wr_en && sel == SEL_EEN),
    .dis_stb (wr_en && sel == SEL_EDIS),
    .wbits   (bus_wdata[EVT_W-1:0]),
    .sts_q   (ev_sts),
    .msk_q   (ev_msk),
    .irq     (irq_rtc)
  );

  rtcr_irq_grp #(.W(AER_W)) u_ae (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (aerr_evt),
    .w1c_stb (wr_en && sel == SEL_ASTS),
    .en_stb  (wr_en && sel == SEL_AEN),
    .dis_stb (wr_en && sel == SEL_ADIS),
    .wbits   (bus_wdata[AER_W-1:0]),
    .sts_q   (ae_sts),
    .msk_q   (ae_msk),
    .irq     (irq_aerr)
  );

  always_comb begin
    case (sel)
      SEL_SETR, SEL_TIME: bus_rdata = sec_q;
      SEL_CALR:  bus_rdata = DATA_W'(calib_q);
      SEL_TICK:  bus_rdata = DATA_W'(tick_q);
      SEL_ALARM: bus_rdata = alarm_q;
      SEL_ESTS:  bus_rdata = DATA_W'(ev_sts);
      SEL_EMSK:  bus_rdata = DATA_W'(ev_msk);
      SEL_ASTS:  bus_rdata = DATA_W'(ae_sts);
      SEL_AMSK:  bus_rdata = DATA_W'(ae_msk);
      SEL_CTRL:  bus_rdata = ctrl_q;
      SEL_SAFE:  bus_rdata = safe_q;
      default:   bus_rdata = '0;
    endcase
  end

  // R8: a stray access is recorded in the address-error status
  a_r8_stray: assert property (@(posedge clk) disable iff (!rst_n)
    aerr_evt |=> ae_sts[0]);
  // R10: alarm changes only through its own write
  a_r10_alarm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_ALARM) |=> $stable(alarm_q));
  // R9: control changes only through its own write
  a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_CTRL) |=> $stable(ctrl_q));
  // R1: calibration changes only through its write offset
  a_r1_cal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_CALW) |=> $stable(calib_q));

endmodule

// File: tb/tb_rtcr_top.sv
module tb_rtcr_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_pulse = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_rtc, irq_aerr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtcr_top #(.ADDR_W(8), .CAL_RST(4)) dut (
    .clk(clk), .rst_n(rst_n), .tick_pulse(tick_pulse),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_rtc(irq_rtc), .irq_aerr(irq_aerr)
  );

  // {write?, write addr, write data, read addr, expected read}
  localparam int NV = 16;
  localparam logic [80:0] VEC [NV] = '{
    {1'b1, 8'h40, 32'hFFFF_FFFF, 8'h40, 32'h8F00_0001}, // R9 reserved bits
    {1'b1, 8'h40, 32'h0000_0000, 8'h40, 32'h0000_0000}, // R9
    {1'b1, 8'h50, 32'hA5A5_5A5A, 8'h50, 32'hA5A5_5A5A}, // R10 safety
    {1'b1, 8'h18, 32'h0000_0010, 8'h18, 32'h0000_0010}, // R10 alarm
    {1'b1, 8'h28, 32'h0000_0003, 8'h28, 32'h0000_0000}, // R6 enable reads 0
    {1'b0, 8'h00, 32'h0000_0000, 8'h24, 32'h0000_0000}, // R6 mask cleared
    {1'b1, 8'h2C, 32'h0000_0001, 8'h24, 32'h0000_0001}, // R6 disable bit0
    {1'b1, 8'h24, 32'h0000_0003, 8'h24, 32'h0000_0001}, // R6 mask not writable
    {1'b1, 8'h08, 32'h0000_0003, 8'h0C, 32'h0000_0003}, // R1 calib readback
    {1'b0, 8'h00, 32'h0000_0000, 8'h08, 32'h0000_0000}, // R1 calib write reads 0
    {1'b1, 8'h10, 32'h0000_1234, 8'h10, 32'h0000_0000}, // R1 time read-only
    {1'b1, 8'h14, 32'h0000_FFFF, 8'h14, 32'h0000_0000}, // R1 tick read-only
    {1'b1, 8'h00, 32'h0000_0100, 8'h04, 32'h0000_0000}, // R3 not loaded yet
    {1'b0, 8'h00, 32'h0000_0000, 8'h00, 32'h0000_0000}, // R1 set-time reads 0
    {1'b1, 8'h0C, 32'h000F_FFFF, 8'h0C, 32'h0000_0003}, // R1 calib read-only
    {1'b1, 8'h34, 32'h0000_0000, 8'h34, 32'h0000_0001}  // R8 mask read-only
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    tick_pulse = 1'b0; bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    tick_pulse = 1'b0; bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
    #2 d = bus_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
    tick_pulse = 1'b0; bus_req = 1'b0; bus_wr = 1'b0;
    #2;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_pulse = 1'b1; bus_req = 1'b0; bus_wr = 1'b0;
    end
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bread(a, v);
    chk(req, v, exp);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    idle();
    chk("R11 irq_rtc", {31'd0, irq_rtc}, 32'd0);
    chk("R11 irq_aerr", {31'd0, irq_aerr}, 32'd0);
    rchk("R6 event mask reset", 8'h24, 32'h3);
    rchk("R8 aerr mask reset", 8'h34, 32'h1);
    rchk("R9 control reset", 8'h40, 32'h0100_0000);
    rchk("R11 calib reset", 8'h0C, 32'd4);
    rchk("R11 seconds reset", 8'h10, 32'd0);
    rchk("R11 status reset", 8'h20, 32'd0);
    rchk("R11 aerr status reset", 8'h30, 32'd0);

    // register table
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][80]) bwrite(VEC[k][79:72], VEC[k][71:40]);
      bread(VEC[k][39:32], v);
      chk($sformatf("table entry %0d (R1/R3/R6/R8/R9/R10)", k), v, VEC[k][31:0]);
    end
    rchk("R8 no stray access in table", 8'h30, 32'd0);

    // R2 tick counting with limit 3
    pulses(3);
    rchk("R2 tick at 3", 8'h14, 32'd3);
    rchk("R2 seconds still 0", 8'h10, 32'd0);
    // R3 boundary loads pending set-time
    pulses(1);
    rchk("R3 loaded seconds", 8'h10, 32'h100);
    rchk("R2 tick wrapped", 8'h14, 32'd0);
    rchk("R4 second event", 8'h20, 32'h1);
    idle();
    chk("R7 masked event no irq", {31'd0, irq_rtc}, 32'd0);
    bwrite(8'h28, 32'h1);
    idle();
    chk("R7 unmasked event irq", {31'd0, irq_rtc}, 32'd1);
    bwrite(8'h20, 32'h1);
    idle();
    chk("R7 irq drops after clear", {31'd0, irq_rtc}, 32'd0);
    rchk("R5 cleared", 8'h20, 32'd0);

    // R4 alarm
    bwrite(8'h18, 32'h102);
    pulses(4);
    rchk("R2 increment", 8'h04, 32'h101);
    rchk("R4 no alarm yet", 8'h20, 32'h1);
    bwrite(8'h20, 32'h0);
    rchk("R5 zero write keeps", 8'h20, 32'h1);
    bwrite(8'h20, 32'h1);
    pulses(4);
    rchk("R4 alarm hit", 8'h20, 32'h3);
    idle();
    chk("R7 irq on alarm", {31'd0, irq_rtc}, 32'd1);
    bwrite(8'h20, 32'h2);
    rchk("R5 partial clear", 8'h20, 32'h1);
    bwrite(8'h20, 32'h1);

    // R5 event wins over same-cycle clear
    pulses(3);
    @(negedge clk);
    tick_pulse = 1'b1; bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h1;
    rchk("R5 set beats clear", 8'h20, 32'h1);
    rchk("R2 seconds 0x103", 8'h10, 32'h103);

    // R6/R7 disable hides pending status
    bwrite(8'h2C, 32'h3);
    idle();
    chk("R7 disabled no irq", {31'd0, irq_rtc}, 32'd0);
    rchk("R6 mask set", 8'h24, 32'h3);
    bwrite(8'h20, 32'h3);

    // R8 address errors
    rchk("R8 gap reads zero", 8'h1C, 32'd0);
    rchk("R8 gap flagged", 8'h30, 32'h1);
    idle();
    chk("R8 masked aerr irq", {31'd0, irq_aerr}, 32'd0);
    bwrite(8'h38, 32'h1);
    idle();
    chk("R8 aerr irq", {31'd0, irq_aerr}, 32'd1);
    rchk("R8 aerr mask clear", 8'h34, 32'd0);
    bwrite(8'h30, 32'h1);
    idle();
    chk("R8 aerr irq cleared", {31'd0, irq_aerr}, 32'd0);
    rchk("R8 misaligned reads zero", 8'h42, 32'd0);
    rchk("R8 misaligned flagged", 8'h30, 32'h1);
    bwrite(8'h30, 32'h1);
    bwrite(8'h60, 32'hFFFF_FFFF);
    rchk("R8 write past window flagged", 8'h30, 32'h1);
    rchk("R10 safety untouched", 8'h50, 32'hA5A5_5A5A);
    bwrite(8'h51, 32'h0);
    rchk("R8 misaligned write ignored", 8'h50, 32'hA5A5_5A5A);

    // R2 limit 0: every pulse is a boundary
    bwrite(8'h08, 32'h0);
    pulses(2);
    rchk("R2 limit zero", 8'h10, 32'h105);

    done = 1'b1;
    finish_run();
  end

endmodule